// File: doc/BRIEF.md
# Latched-Byte Nonvolatile Array Program and Erase Sequencer

This block sits between a CPU register bus and a small byte-wide nonvolatile array, held here as on-chip register storage. Software never writes the array directly. It first sets a latch-enable bit in a control register. It then issues one array write, which captures one address and one data byte. It raises a program-voltage bit, waits, and lowers that bit again. The falling edge of the program-voltage bit commits the latched operation. The commit goes through only if the voltage stayed on for at least `MIN_CYC` clock cycles.

The control register also holds three mode bits: erase, row and byte. Together they select one of four operations at commit: clear bits (program), erase one byte, erase an aligned 16-byte row, or erase the whole array. The last array location holds a configuration byte. Writes to the configuration address are redirected to that location and follow the same latch-and-commit sequence. A live copy of the configuration byte is loaded only when the CPU reset is released, and its enable bit decides whether the array answers on the bus.

Each illegal sequence produces a one-cycle error pulse with a code, and the offending access is rejected. The CPU reset `rst_n` clears the sequencer state only. The separate power-on reset `por_n` fills the array with 0xFF.

Top module: `nvm_prog_seq`

## Requirements
- R1: After `rst_n` is released, a control read returns 0x00, no byte is latched, and one cycle later the live configuration is loaded from the last array byte. Array contents survive `rst_n`; `por_n` sets every byte to 0xFF.
- R2: A control write whose latch-enable bit (bit 1) is 0 sets the whole control register to 0x00 and discards any latched byte.
- R3: A control write that raises latch-enable (bit 1) and program-voltage (bit 0) together from 0 is rejected with error code 1, and the control register keeps its value.
- R4: A control write that raises program-voltage while no byte is latched is rejected with error code 2, and the control register keeps its value.
- R5: An array or configuration write while latch-enable is 0 gives error code 4 and latches nothing. A write while a byte is already latched gives error code 5 and keeps the first address and data.
- R6: An array read while latch-enable is 1 gives error code 6 and read data 0x00.
- R7: Lowering program-voltage fewer than `MIN_CYC` cycles after raising it gives error code 3. The array is unchanged, the latched byte is dropped, and the control register takes the written value.
- R8: With erase (bit 2) clear, a commit ANDs the latched data into the addressed byte, so bits only go from 1 to 0.
- R9: With erase set, a commit erases only the addressed byte to 0xFF when byte (bit 4) is set or when the latched address is the configuration location.
- R10: With erase and row (bit 3) set, byte clear, and a non-configuration address, a commit sets the 16 bytes whose address matches the latched address above its low 4 bits to 0xFF, and leaves all other bytes as they were.
- R11: With erase set and neither row nor byte, a commit sets every location, the configuration byte included, to 0xFF.
- R12: A configuration write (select 2) targets the last array location. A configuration read returns the live copy, which changes only at reset release.
- R13: When bit 0 of the live configuration is 0, array reads return 0x00 and array writes are ignored without error. Control and configuration accesses still work.
- R14: Read data and error responses appear in the cycle after the access. An error pulse lasts one cycle, and cycles without an access never show an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low CPU reset for the sequencer state |
| por_n | input | 1 | Asynchronous active-low power-on reset that fills the array with 0xFF |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe (ignored when `bus_wr` is high) |
| bus_sel | input | 2 | Target: 0 array, 1 control, 2 configuration, 3 none |
| bus_addr | input | ADDR_W | Array byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| err_valid | output | 1 | One-cycle error pulse |
| err_code | output | 3 | Error code: 1 dual rise, 2 no data, 3 short pulse, 4 no latch, 5 busy, 6 read while latched |
| arr_mapped | output | 1 | The array currently answers on the bus |

## Verification
Every bus access is answered at the next rising edge: read data and any error code can be observed from just after that edge until the following one. A commit happens at the same edge as the write that lowers program-voltage, so a read issued in the very next cycle already returns the new contents. The live configuration is loaded at the first edge after `rst_n` rises, so the bench leaves one idle cycle before it checks decoding. The driver queues one expected response per access. A monitor samples 1 ns after each edge and checks that response only when an access was issued in the cycle before. On every other cycle it checks that no error is present. Program-voltage pulse lengths are set in whole cycles, one below and exactly at `MIN_CYC`, to cover the pass/fail boundary.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  localparam int CTL_W   = 5;
  localparam int B_VPP   = 0;
  localparam int B_LATCH = 1;
  localparam int B_ERASE = 2;
  localparam int B_ROW   = 3;
  localparam int B_BYTE  = 4;
  localparam int CFG_EN  = 0;

  typedef enum logic [1:0] {
    SEL_ARR  = 2'd0,
    SEL_CTL  = 2'd1,
    SEL_CFG  = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  typedef enum logic [2:0] {
    E_NONE       = 3'd0,
    E_DUAL_RISE  = 3'd1,
    E_NO_DATA    = 3'd2,
    E_SHORT      = 3'd3,
    E_NO_LATCH   = 3'd4,
    E_BUSY       = 3'd5,
    E_RD_LATCHED = 3'd6
  } err_e;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_BYTE = 2'd1,
    OP_ROW  = 2'd2,
    OP_BULK = 2'd3
  } op_e;
endpackage

// File: rtl/nvs_ctl.sv
module nvs_ctl
  import nvs_pkg::*;
#(
  parameter int MIN_CYC = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_val,
  input  logic             pending,
  output logic [CTL_W-1:0] ctl_q,
  output logic             commit,
  output logic             discard,
  output err_e             err
);
  localparam int CNT_W = $clog2(MIN_CYC + 1);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_CYC);

  logic [CTL_W-1:0] ctl_d, nv;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dual, up, dn;

  always_comb begin
    nv = wr_val;
    if (!nv[B_LATCH]) nv = '0;
    dual = wr_val[B_LATCH] & ~ctl_q[B_LATCH] & wr_val[B_VPP] & ~ctl_q[B_VPP];
    up   = nv[B_VPP] & ~ctl_q[B_VPP];
    dn   = ctl_q[B_VPP] & ~nv[B_VPP];
    ctl_d   = ctl_q;
    cnt_d   = cnt_q;
    commit  = 1'b0;
    discard = 1'b0;
    err     = E_NONE;
    if (ctl_q[B_VPP] && (cnt_q < MIN_V)) cnt_d = cnt_q + 1'b1;
    if (wr_en) begin
      if (dual) begin
        err = E_DUAL_RISE;
      end else if (up && !pending) begin
        err = E_NO_DATA;
      end else begin
        ctl_d = nv;
        if (up) cnt_d = CNT_W'(1);
        if (dn) begin
          if (cnt_q >= MIN_V) begin
            commit = 1'b1;
          end else begin
            err     = E_SHORT;
            discard = 1'b1;
          end
        end else if (!nv[B_LATCH]) begin
          discard = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      cnt_q <= '0;
    end else begin
      ctl_q <= ctl_d;
      cnt_q <= cnt_d;
    end
  end

  assert_vpp_needs_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[B_VPP] |-> ctl_q[B_LATCH]);

  assert_dual_rise_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_val[B_LATCH] && wr_val[B_VPP] && !ctl_q[B_LATCH]) |=> $stable(ctl_q));

  assert_latch_off_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_val[B_LATCH]) |=> (ctl_q == '0));
endmodule

// File: rtl/nvs_latch.sv
module nvs_latch
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              latch_on,
  input  logic              clear,
  output logic              pending_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [7:0]        data_q,
  output err_e              err
);
  logic take;

  always_comb begin
    take = 1'b0;
    err  = E_NONE;
    if (wr_en) begin
      if (!latch_on)      err  = E_NO_LATCH;
      else if (pending_q) err  = E_BUSY;
      else                take = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
    end else begin
      if (take) begin
        pending_q <= 1'b1;
        addr_q    <= wr_addr;
        data_q    <= wr_data;
      end else if (clear) begin
        pending_q <= 1'b0;
      end
    end
  end

  assert_latch_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && wr_en) |=> ($stable(addr_q) && $stable(data_q)));
endmodule

// File: rtl/nvs_array.sv
module nvs_array
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int ROW_W  = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              commit,
  input  op_e               op,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [7:0]        l_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_byte,
  output logic [7:0]        cfg_byte
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem_w [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
    logic [7:0] ent_q, ent_d;
    logic       hit_byte, hit_row;

    always_comb begin
      hit_byte = (l_addr == IDX);
      hit_row  = (l_addr[ADDR_W-1:ROW_W] == IDX[ADDR_W-1:ROW_W]);
      ent_d    = ent_q;
      if (commit) begin
        case (op)
          OP_PROG: if (hit_byte) ent_d = ent_q & l_data;
          OP_BYTE: if (hit_byte) ent_d = 8'hFF;
          OP_ROW:  if (hit_row)  ent_d = 8'hFF;
          default: ent_d = 8'hFF;
        endcase
      end
    end

    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) ent_q <= 8'hFF;
      else        ent_q <= ent_d;
    end

    assign mem_w[i] = ent_q;

    assert_prog_no_set_R8: assert property (@(posedge clk) disable iff (!por_n)
      (commit && op == OP_PROG) |=> ((ent_q & ~$past(ent_q)) == 8'h00));

    assert_bulk_fills_R11: assert property (@(posedge clk) disable iff (!por_n)
      (commit && op == OP_BULK) |=> (ent_q == 8'hFF));
  end

  assign rd_byte  = mem_w[rd_addr];
  assign cfg_byte = mem_w[DEPTH-1];
endmodule

// File: rtl/nvm_prog_seq.sv
module nvm_prog_seq
  import nvs_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int ROW_W   = 4,
  parameter int MIN_CYC = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              err_valid,
  output logic [2:0]        err_code,
  output logic              arr_mapped
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  sel_e              sel;
  logic [CTL_W-1:0]  ctl_q;
  logic              commit, discard, pending;
  logic              ctl_wr, lat_wr, rd_go;
  logic [ADDR_W-1:0] lat_addr, l_addr;
  logic [7:0]        l_data, arr_byte, cfg_byte;
  logic [7:0]        cfg_live, rd_d, rdata_q;
  logic              reload_q, mapped;
  err_e              ctl_err, lat_err, rd_err, err_d;
  logic [2:0]        err_q;
  op_e               op;

  assign sel      = sel_e'(bus_sel);
  assign mapped   = cfg_live[CFG_EN] & ~reload_q;
  assign ctl_wr   = bus_wr && (sel == SEL_CTL);
  assign lat_wr   = bus_wr && (((sel == SEL_ARR) && mapped) || (sel == SEL_CFG));
  assign lat_addr = (sel == SEL_CFG) ? LAST : bus_addr;
  assign rd_go    = bus_rd && !bus_wr;

  nvs_ctl #(.MIN_CYC(MIN_CYC)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr), .wr_val(bus_wdata[CTL_W-1:0]),
    .pending(pending), .ctl_q(ctl_q), .commit(commit), .discard(discard),
    .err(ctl_err)
  );

  nvs_latch #(.ADDR_W(ADDR_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .wr_en(lat_wr), .wr_addr(lat_addr),
    .wr_data(bus_wdata), .latch_on(ctl_q[B_LATCH]), .clear(commit | discard),
    .pending_q(pending), .addr_q(l_addr), .data_q(l_data), .err(lat_err)
  );

  always_comb begin
    if (!ctl_q[B_ERASE])                       op = OP_PROG;
    else if (ctl_q[B_BYTE] || (l_addr == LAST)) op = OP_BYTE;
    else if (ctl_q[B_ROW])                     op = OP_ROW;
    else                                       op = OP_BULK;
  end

  nvs_array #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_arr (
    .clk(clk), .por_n(por_n), .commit(commit), .op(op), .l_addr(l_addr),
    .l_data(l_data), .rd_addr(bus_addr), .rd_byte(arr_byte), .cfg_byte(cfg_byte)
  );

  always_comb begin
    rd_d   = 8'h00;
    rd_err = E_NONE;
    case (sel)
      SEL_CTL: rd_d = {{(8-CTL_W){1'b0}}, ctl_q};
      SEL_CFG: rd_d = cfg_live;
      SEL_ARR: begin
        if (mapped) begin
          if (ctl_q[B_LATCH]) rd_err = E_RD_LATCHED;
          else                rd_d   = arr_byte;
        end
      end
      default: rd_d = 8'h00;
    endcase
    if (!rd_go) rd_err = E_NONE;
    err_d = err_e'(ctl_err | lat_err | rd_err);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_live <= '0;
      reload_q <= 1'b1;
    end else if (reload_q) begin
      cfg_live <= cfg_byte;
      reload_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= '0;
    end else begin
      if (rd_go) rdata_q <= rd_d;
      err_q <= err_d;
    end
  end

  assign bus_rdata  = rdata_q;
  assign err_code   = err_q;
  assign err_valid  = (err_q != 3'd0);
  assign arr_mapped = mapped;

  assert_vpp_has_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[B_VPP] |-> pending);

  assert_read_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && sel == SEL_ARR && mapped && ctl_q[B_LATCH])
      |=> (err_valid && err_code == 3'd6 && bus_rdata == 8'h00));

  assert_cfg_live_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !reload_q |=> $stable(cfg_live));

  assert_unmapped_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_ARR && !mapped) |=> !err_valid);

  assert_idle_no_err_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && !bus_rd) |=> !err_valid);
endmodule

// File: tb/sim_nvm_prog_seq.sv
`timescale 1ns/1ps
module sim_nvm_prog_seq;
  localparam int MINC = 20;
  localparam logic [1:0] S_ARR = 2'd0, S_CTL = 2'd1, S_CFG = 2'd2;
  localparam logic [7:0] VPP = 8'h01, LAT = 8'h02, ERA = 8'h04, ROW = 8'h08, BYT = 8'h10;

  logic clk = 1'b0;
  logic rst_n = 1'b0, por_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_sel = 2'd3;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic err_valid, arr_mapped;
  logic [2:0] err_code;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct {
    logic       chk_rd;
    logic [7:0] rd;
    logic [2:0] code;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  nvm_prog_seq #(.ADDR_W(6), .ROW_W(4), .MIN_CYC(MINC)) u0 (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .err_valid(err_valid), .err_code(err_code),
    .arr_mapped(arr_mapped)
  );

  // monitor: pops one expected item for every access of the previous cycle
  always @(posedge clk) begin
    logic act;
    act = bus_wr | bus_rd;
    if (rst_n && !done) begin
      #1;
      if (act) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (err_valid !== (e.code != 3'd0) || err_code !== e.code) begin
          fails++;
          $display("FAIL %s err_code actual=%0d expected=%0d", e.tag, err_code, e.code);
        end
        if (e.chk_rd) begin
          checks++;
          if (bus_rdata !== e.rd) begin
            fails++;
            $display("FAIL %s rdata actual=%02h expected=%02h", e.tag, bus_rdata, e.rd);
          end
        end
      end else begin
        checks++;
        if (err_valid !== 1'b0) begin
          fails++;
          $display("FAIL R14 idle err actual=%0d expected=0", err_valid);
        end
      end
    end
  end

  task automatic op(input logic w, input logic [1:0] s, input logic [5:0] a,
                    input logic [7:0] d, input logic chk, input logic [7:0] er,
                    input logic [2:0] ec, input string tag);
    exp_t e;
    @(negedge clk);
    bus_wr = w; bus_rd = ~w; bus_sel = s; bus_addr = a; bus_wdata = d;
    e.chk_rd = chk; e.rd = er; e.code = ec; e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
    #1;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_sel = 2'd3;
  endtask

  task automatic wr_ctl(input logic [7:0] d, input logic [2:0] ec, input string tag);
    op(1'b1, S_CTL, 6'd0, d, 1'b0, 8'h00, ec, tag);
  endtask
  task automatic wr_arr(input logic [5:0] a, input logic [7:0] d, input logic [2:0] ec, input string tag);
    op(1'b1, S_ARR, a, d, 1'b0, 8'h00, ec, tag);
  endtask
  task automatic rd_arr(input logic [5:0] a, input logic [7:0] x, input logic [2:0] ec, input string tag);
    op(1'b0, S_ARR, a, 8'h00, 1'b1, x, ec, tag);
  endtask
  task automatic rd_ctl(input logic [7:0] x, input string tag);
    op(1'b0, S_CTL, 6'd0, 8'h00, 1'b1, x, 3'd0, tag);
  endtask
  task automatic rd_cfg(input logic [7:0] x, input string tag);
    op(1'b0, S_CFG, 6'd0, 8'h00, 1'b1, x, 3'd0, tag);
  endtask

  // full sequence: latch, write, voltage on for k cycles, voltage off, latch off
  task automatic seq(input logic [7:0] mode, input logic [1:0] s, input logic [5:0] a,
                     input logic [7:0] d, input int k, input string tag);
    wr_ctl(mode | LAT, 3'd0, tag);
    op(1'b1, s, a, d, 1'b0, 8'h00, 3'd0, tag);
    wr_ctl(mode | LAT | VPP, 3'd0, tag);
    repeat (k - 1) @(posedge clk);
    wr_ctl(mode | LAT, (k >= MINC) ? 3'd0 : 3'd3, tag);
    wr_ctl(8'h00, 3'd0, tag);
  endtask

  task automatic cpu_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    repeat (2) @(posedge clk);
    // R1 reset state
    rd_ctl(8'h00, "R1 ctl after reset");
    rd_cfg(8'hFF, "R1 cfg loaded");
    rd_arr(6'd5, 8'hFF, 3'd0, "R1 array erased");
    // R5 write without latch
    wr_arr(6'd3, 8'h00, 3'd4, "R5 no latch");
    rd_arr(6'd3, 8'hFF, 3'd0, "R5 no latch effect");
    // R3 dual rise
    wr_ctl(LAT | VPP, 3'd1, "R3 dual rise");
    rd_ctl(8'h00, "R3 ctl kept");
    // R6 read while latched, R4 voltage without data
    wr_ctl(LAT, 3'd0, "R4 setup");
    rd_arr(6'd3, 8'h00, 3'd6, "R6 read while latched");
    wr_ctl(LAT | VPP, 3'd2, "R4 no data");
    rd_ctl(LAT, "R4 ctl kept");
    // R5 busy, R8 program
    wr_arr(6'd3, 8'hA5, 3'd0, "R5 latch");
    wr_arr(6'd4, 8'h00, 3'd5, "R5 busy");
    wr_ctl(LAT | VPP, 3'd0, "R8 vpp on");
    repeat (MINC - 1) @(posedge clk);
    wr_ctl(LAT, 3'd0, "R8 vpp off");
    wr_ctl(8'h00, 3'd0, "R8 latch off");
    rd_arr(6'd3, 8'hA5, 3'd0, "R8 programmed");
    rd_arr(6'd4, 8'hFF, 3'd0, "R5 second write dropped");
    seq(8'h00, S_ARR, 6'd3, 8'h5F, MINC, "R8 and");
    rd_arr(6'd3, 8'h05, 3'd0, "R8 only clears");
    // R7 short pulse and R2 latch-off clear
    seq(8'h00, S_ARR, 6'd7, 8'h00, MINC - 1, "R7 short");
    rd_arr(6'd7, 8'hFF, 3'd0, "R7 array unchanged");
    wr_ctl(LAT, 3'd0, "R7 relatch");
    wr_arr(6'd7, 8'h0F, 3'd0, "R7 latch dropped");
    wr_ctl(ERA | ROW | BYT, 3'd0, "R2 latch off");
    rd_ctl(8'h00, "R2 cleared");
    rd_arr(6'd7, 8'hFF, 3'd0, "R2 latched byte discarded");
    // setup data
    seq(8'h00, S_ARR, 6'd16, 8'h11, MINC, "R9 setup");
    seq(8'h00, S_ARR, 6'd31, 8'h22, MINC, "R10 setup");
    seq(8'h00, S_ARR, 6'd32, 8'h33, MINC, "R10 setup");
    seq(8'h00, S_ARR, 6'd15, 8'h44, MINC, "R10 setup");
    seq(8'h00, S_ARR, 6'd48, 8'h55, MINC, "R9 setup");
    // R9 byte erase
    seq(ERA | BYT, S_ARR, 6'd16, 8'h00, MINC, "R9 byte erase");
    rd_arr(6'd16, 8'hFF, 3'd0, "R9 byte erased");
    rd_arr(6'd31, 8'h22, 3'd0, "R9 neighbour kept");
    // R10 row erase
    seq(8'h00, S_ARR, 6'd16, 8'h11, MINC, "R10 setup");
    seq(ERA | ROW, S_ARR, 6'd19, 8'h00, MINC, "R10 row erase");
    rd_arr(6'd16, 8'hFF, 3'd0, "R10 row start");
    rd_arr(6'd31, 8'hFF, 3'd0, "R10 row end");
    rd_arr(6'd15, 8'h44, 3'd0, "R10 below row kept");
    rd_arr(6'd32, 8'h33, 3'd0, "R10 above row kept");
    // R12 config redirect
    seq(8'h00, S_CFG, 6'd0, 8'h3E, MINC, "R12 cfg write");
    rd_cfg(8'hFF, "R12 live unchanged");
    rd_arr(6'd63, 8'h3E, 3'd0, "R12 redirected");
    // R13 unmapped after reset
    cpu_reset();
    rd_ctl(8'h00, "R1 ctl after cpu reset");
    rd_cfg(8'h3E, "R1 cfg reloaded");
    rd_arr(6'd3, 8'h00, 3'd0, "R13 unmapped read");
    wr_arr(6'd3, 8'h00, 3'd0, "R13 unmapped write quiet");
    // R9 config location erases one byte even in row mode
    seq(ERA | ROW, S_CFG, 6'd0, 8'h00, MINC, "R9 cfg erase");
    cpu_reset();
    rd_cfg(8'hFF, "R9 cfg erased");
    rd_arr(6'd48, 8'h55, 3'd0, "R9 cfg row kept");
    rd_arr(6'd3, 8'h05, 3'd0, "R1 array survives reset");
    // R11 bulk erase
    seq(ERA, S_ARR, 6'd0, 8'h00, MINC, "R11 bulk");
    rd_arr(6'd3, 8'hFF, 3'd0, "R11 bulk low");
    rd_arr(6'd48, 8'hFF, 3'd0, "R11 bulk high");
    rd_arr(6'd32, 8'hFF, 3'd0, "R11 bulk mid");
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R14 pending responses actual=%0d expected=0", sb.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule